// File: doc/BRIEF.md
# Column-Truncated Approximate Array Multiplier

This block multiplies two unsigned operands with a regular carry-save array of adder cells. A final ripple row resolves the array into the product. To save area and energy, every partial product and every cell whose weight is below a chosen column is removed. The product bits below that column are held at zero.

Cells at the cut column lose the carry input that a removed neighbour used to drive. A fixed number of these cells, taken from the bottom rows of the array, take a constant in place of that carry. The `CONST_MODE` parameter picks the constant. With constant 0, each such cell becomes a half adder. With constant 1, each becomes a two-input XNOR that gives the sum and a two-input OR that gives the carry. The other cut-column cells that lost their carry are plain two-input half adders, never full adders with a constant input. A register on the product is optional.

At the defaults the operands are 8 bits, the product is 16 bits, the cut is at column 7 and four cells take the constant. The block suits error-tolerant datapaths such as filters and image kernels, where a small, bounded, one-sided error is acceptable.

Top module: `approx_array_mult`

## Requirements
- R1: With `CONST_MODE`=0, `p` equals the sum of every partial product `a[i]&b[j]` with `i+j >= CUT`, each weighted by 2^(i+j), taken modulo 2^(2*WIDTH).
- R2: Bits `p[CUT-1:0]` are 0 for every operand pair and in both modes.
- R3: With `CONST_MODE`=1, `p` equals the R1 sum plus `TIED_CELLS`·2^CUT, modulo 2^(2*WIDTH). At the defaults the added amount is 512.
- R4: When `a`=0 or `b`=0, `p` is 0 in mode 0. In mode 1 it is `TIED_CELLS`·2^CUT (512 at the defaults), a known error of the constant-1 variant.
- R5: In mode 0, `p` never exceeds `a*b`. The shortfall is at most (CUT-1)·2^CUT+1, which is 769 at the defaults and is reached at a=b=255.
- R6: In mode 1, `p` exceeds `a*b` by at most `TIED_CELLS`·2^CUT (512), which is reached when a removed term sum is 0. `p` falls short of `a*b` by at most 769−512 = 257 at the defaults.
- R7: With `OUT_REG`=1, `p` reflects the operands sampled at the previous rising edge of `clk`. A change on `a` or `b` does not reach `p` before the next edge.
- R8: While `rst_n` is low, `p` is 0, whatever the operands are. The reset is asynchronous and active low, and it applies when `OUT_REG`=1.
- R9: When `a[CUT-1:0]` is 0, no partial product is removed. In that case `p` equals `a*b` in mode 0 and `a*b + TIED_CELLS·2^CUT` modulo 2^(2*WIDTH) in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional product register |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| a | input | WIDTH | Unsigned multiplicand |
| b | input | WIDTH | Unsigned multiplier |
| p | output | 2*WIDTH | Approximate product, low CUT bits zero |

## Verification
A miswired or mis-typed cell anywhere in the kept array shifts the product by a power of two for every operand pair that excites that cell. The product register adds one cycle, so such a fault shows at `p` one edge after the operands are presented. A wrong cell kind on the cut column shows even with a zero operand, because mode 0 then gives a nonzero product or mode 1 gives a value other than 512. A lost carry between rows shows as a deficit larger than the removed-term bound. Sweeping all operand pairs in both modes against the arithmetic model therefore exposes any single-cell fault within one cycle of the pair that triggers it.

// File: rtl/amul_pkg.sv
package amul_pkg;

   // kinds of adder cell a position in the truncated array can hold
   typedef enum logic [1:0] {
      CK_FULL,
      CK_HALF,
      CK_XNOR_OR
   } cell_kind_e;

   // lowest array row whose cut-column cell lost its carry input
   function automatic int first_edge_row(input int width, input int cut);
      int lo;
      lo = cut - width + 2;
      return (lo > 2) ? lo : 2;
   endfunction

   // highest array row whose cut-column cell lost its carry input
   function automatic int last_edge_row(input int width, input int cut);
      return (cut < width - 1) ? cut : width - 1;
   endfunction

   // number of cut-column cells that lost their carry input
   function automatic int edge_cell_count(input int width, input int cut);
      return last_edge_row(width, cut) - first_edge_row(width, cut) + 1;
   endfunction

   // cell kind for array row 'row', column 'col'
   function automatic cell_kind_e pick_kind(input int row, input int col, input int cut,
                                            input int tie_from_row, input int mode);
      if (row == 1)
         return CK_HALF;
      if (row + col != cut)
         return CK_FULL;
      if (mode == 1 && row >= tie_from_row)
         return CK_XNOR_OR;
      return CK_HALF;
   endfunction

endpackage

// File: rtl/amul_ha.sv
module amul_ha (
   input  logic x,
   input  logic y,
   output logic s,
   output logic co
);
   assign s  = x ^ y;
   assign co = x & y;
endmodule

// File: rtl/amul_fa.sv
module amul_fa (
   input  logic x,
   input  logic y,
   input  logic z,
   output logic s,
   output logic co
);
   logic hs;
   assign hs = x ^ y;
   assign s  = hs ^ z;
   assign co = (x & y) | (hs & z);
endmodule

// File: rtl/amul_xo.sv
module amul_xo (
   input  logic x,
   input  logic y,
   output logic s,
   output logic co
);
   // full adder with its third input fixed at one, reduced
   assign s  = ~(x ^ y);
   assign co = x | y;
endmodule

// File: rtl/amul_cut_array.sv
module amul_cut_array
   import amul_pkg::*;
#(
   parameter int W    = 8,
   parameter int CUT  = 7,
   parameter int NTIE = 4,
   parameter int MODE = 0
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   localparam int PW       = 2 * W;
   localparam int TIE_FROM = last_edge_row(W, CUT) - NTIE + 1;

   // carry-save rows: row r, column i sits at weight i+r
   for (genvar r = 1; r < W; r++) begin : g_row
      for (genvar i = 0; i < W - 1; i++) begin : g_col
         if (i + r >= CUT) begin : g_keep
            localparam cell_kind_e KIND = pick_kind(r, i, CUT, TIE_FROM, MODE);
            logic x, y, s, co;

            assign x = a[i] & b[r];

            if (r == 1) begin : g_y_first
               assign y = a[i+1] & b[0];
            end else if (i == W - 2) begin : g_y_edge
               assign y = a[W-1] & b[r-1];
            end else begin : g_y_inner
               assign y = g_row[r-1].g_col[i+1].g_keep.s;
            end

            if (KIND == CK_FULL) begin : g_full
               amul_fa u_fa (
                  .x (x),
                  .y (y),
                  .z (g_row[r-1].g_col[i].g_keep.co),
                  .s (s),
                  .co(co)
               );
            end else if (KIND == CK_XNOR_OR) begin : g_tied
               amul_xo u_xo (
                  .x (x),
                  .y (y),
                  .s (s),
                  .co(co)
               );
            end else begin : g_half
               amul_ha u_ha (
                  .x (x),
                  .y (y),
                  .s (s),
                  .co(co)
               );
            end
         end
      end
   end

   // final ripple row: cell k sits at weight W+k
   for (genvar k = 0; k < W - 1; k++) begin : g_fin
      logic x, s, co;

      if (k < W - 2) begin : g_x_inner
         assign x = g_row[W-1].g_col[k+1].g_keep.s;
      end else begin : g_x_top
         assign x = a[W-1] & b[W-1];
      end

      if (k == 0) begin : g_start
         amul_ha u_ha (
            .x (x),
            .y (g_row[W-1].g_col[0].g_keep.co),
            .s (s),
            .co(co)
         );
      end else begin : g_chain
         amul_fa u_fa (
            .x (x),
            .y (g_row[W-1].g_col[k].g_keep.co),
            .z (g_fin[k-1].co),
            .s (s),
            .co(co)
         );
      end
   end

   // product assembly
   for (genvar w = 0; w < PW; w++) begin : g_out
      if (w < CUT) begin : g_cut
         assign p[w] = 1'b0;
      end else if (w < W) begin : g_side
         assign p[w] = g_row[w].g_col[0].g_keep.s;
      end else if (w < PW - 1) begin : g_bottom
         assign p[w] = g_fin[w-W].s;
      end else begin : g_msb
         assign p[w] = g_fin[W-2].co;
      end
   end

endmodule

// File: rtl/approx_array_mult.sv
module approx_array_mult
   import amul_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int CUT        = 7,
   parameter int TIED_CELLS = 4,
   parameter int CONST_MODE = 0,
   parameter int OUT_REG    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [2*WIDTH-1:0] p
);
   localparam int PW    = 2 * WIDTH;
   localparam int EDGES = edge_cell_count(WIDTH, CUT);

   // elaboration-time parameter checks
   if (WIDTH < 3) begin : g_bad_width
      $error("approx_array_mult: WIDTH must be at least 3");
   end
   if (CUT < 1 || CUT > WIDTH - 1) begin : g_bad_cut
      $error("approx_array_mult: CUT must lie in 1..WIDTH-1");
   end
   if (CONST_MODE != 0 && CONST_MODE != 1) begin : g_bad_mode
      $error("approx_array_mult: CONST_MODE must be 0 or 1");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("approx_array_mult: OUT_REG must be 0 or 1");
   end
   if (TIED_CELLS < 0 || TIED_CELLS > EDGES) begin : g_bad_ties
      $error("approx_array_mult: TIED_CELLS exceeds cut-column cells with a lost carry");
   end

   logic [PW-1:0] p_comb;

   amul_cut_array #(
      .W   (WIDTH),
      .CUT (CUT),
      .NTIE(TIED_CELLS),
      .MODE(CONST_MODE)
   ) u_array (
      .a(a),
      .b(b),
      .p(p_comb)
   );

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p <= '0;
         else        p <= p_comb;
      end
   end else begin : g_comb
      assign p = p_comb;
   end

endmodule

// File: rtl/approx_array_mult_chk.sv
module approx_array_mult_chk #(
   parameter int WIDTH      = 8,
   parameter int CUT        = 7,
   parameter int TIED_CELLS = 4,
   parameter int CONST_MODE = 0,
   parameter int OUT_REG    = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [WIDTH-1:0]   a,
   input logic [WIDTH-1:0]   b,
   input logic [2*WIDTH-1:0] p
);
   localparam int PW = 2 * WIDTH;
   localparam logic [PW-1:0] LOSS  = PW'((CUT - 1) * (1 << CUT) + 1);
   localparam logic [PW-1:0] BONUS = PW'(TIED_CELLS * (1 << CUT));
   localparam logic [PW-1:0] ADD   = (CONST_MODE == 1) ? BONUS : '0;

   logic [PW-1:0] exact_now, exact_d;
   logic          zero_now, zero_d, lowa_now, lowa_d;

   assign exact_now = PW'(a) * PW'(b);
   assign zero_now  = (a == '0) || (b == '0);
   assign lowa_now  = (a[CUT-1:0] == '0);

   if (OUT_REG == 1) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            exact_d <= '0;
            zero_d  <= 1'b0;
            lowa_d  <= 1'b0;
         end else begin
            exact_d <= exact_now;
            zero_d  <= zero_now;
            lowa_d  <= lowa_now;
         end
      end

      // R8
      reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (p == '0));
   end else begin : g_nodly
      assign exact_d = exact_now;
      assign zero_d  = zero_now;
      assign lowa_d  = lowa_now;
   end

   // R4
   zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_d |-> (p == ADD));

   // R9
   untouched_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lowa_d |-> (p == exact_d + ADD));

   if (CONST_MODE == 0) begin : g_m0
      // R5
      under_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |-> ((p <= exact_d) && ((exact_d - p) <= LOSS)));
   end else begin : g_m1
      // R6
      two_side_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |-> ((p > exact_d) ? ((p - exact_d) <= BONUS)
                                  : ((exact_d - p) <= LOSS)));
   end

endmodule

bind approx_array_mult approx_array_mult_chk #(
   .WIDTH     (WIDTH),
   .CUT       (CUT),
   .TIED_CELLS(TIED_CELLS),
   .CONST_MODE(CONST_MODE),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .a    (a),
   .b    (b),
   .p    (p)
);

// File: tb/test_approx_array_mult.sv
`timescale 1ns/1ps
module test_approx_array_mult;
   localparam int W        = 8;
   localparam int CUT      = 7;
   localparam int TIES     = 4;
   localparam int PW       = 2 * W;
   localparam int LOSS_MAX = (CUT - 1) * (1 << CUT) + 1;   // 769
   localparam int BONUS    = TIES * (1 << CUT);             // 512
   localparam int NPAIRS   = 1 << (2 * W);

   logic          clk = 1'b0;
   logic          rst_n;
   logic [W-1:0]  a, b;
   logic [PW-1:0] p0, p1;

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   int    max_under0 = 0, max_over0 = 0, max_under1 = 0, max_over1 = 0;
   longint sum_abs0 = 0, sum_abs1 = 0;

   always #4 clk = ~clk;   // 125 MHz

   approx_array_mult #(
      .WIDTH(W), .CUT(CUT), .TIED_CELLS(TIES), .CONST_MODE(0), .OUT_REG(1)
   ) i_approx_array_mult (
      .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p0)
   );

   approx_array_mult #(
      .WIDTH(W), .CUT(CUT), .TIED_CELLS(TIES), .CONST_MODE(1), .OUT_REG(1)
   ) i_approx_array_mult_one (
      .clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p1)
   );

   // arithmetic model: kept partial products plus injected constants
   function automatic logic [31:0] model(input int unsigned x, input int unsigned y, input int mode);
      int unsigned acc = 0;
      for (int i = 0; i < W; i++)
         for (int j = 0; j < W; j++)
            if ((i + j >= CUT) && (((x >> i) & 1) == 1) && (((y >> j) & 1) == 1))
               acc += 32'd1 << (i + j);
      if (mode == 1) acc += BONUS;
      return acc & 32'h0000_FFFF;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic sample(input int unsigned pa, input int unsigned pb);
      int unsigned ex;
      int d0, d1;
      ex = pa * pb;
      check("R1 mode0 product", p0, model(pa, pb, 0));
      check("R3 mode1 product", p1, model(pa, pb, 1));
      check("R2 low bits zero", {p0[CUT-1:0], p1[CUT-1:0]}, 0);
      if (pa == 0 || pb == 0) begin
         check("R4 zero operand mode0", p0, 0);
         check("R4 zero operand mode1 known error", p1, BONUS);
      end
      if ((pa % (1 << CUT)) == 0) begin
         check("R9 untouched mode0", p0, ex);
         check("R9 untouched mode1", p1, (ex + BONUS) & 32'hFFFF);
      end
      d0 = int'(p0) - int'(ex);
      d1 = int'(p1) - int'(ex);
      if (d0 > max_over0)  max_over0  = d0;
      if (-d0 > max_under0) max_under0 = -d0;
      if (d1 > max_over1)  max_over1  = d1;
      if (-d1 > max_under1) max_under1 = -d1;
      sum_abs0 += (d0 < 0) ? -d0 : d0;
      sum_abs1 += (d1 < 0) ? -d1 : d1;
   endtask

   initial begin
      int unsigned pa, pb;
      logic [31:0] last0, last1;
      rst_n = 1'b0;
      a = '1;
      b = '1;
      repeat (3) @(negedge clk);
      check("R8 reset mode0", p0, 0);
      check("R8 reset mode1", p1, 0);
      rst_n = 1'b1;
      a = '0;
      b = '0;
      pa = 0;
      pb = 0;
      for (int n = 0; n <= NPAIRS; n++) begin
         @(negedge clk);
         sample(pa, pb);
         last0 = model(pa, pb, 0);
         last1 = model(pa, pb, 1);
         if (n < NPAIRS) begin
            pa = n / (1 << W);
            pb = n % (1 << W);
            a  = W'(pa);
            b  = W'(pb);
            #1;
            check("R7 held until edge mode0", p0, last0);
            check("R7 held until edge mode1", p1, last1);
         end
      end
      check("R5 mode0 never over", max_over0, 0);
      check("R5 mode0 worst shortfall", max_under0, LOSS_MAX);
      check("R6 mode1 worst excess", max_over1, BONUS);
      check("R6 mode1 worst shortfall", max_under1, LOSS_MAX - BONUS);
      $display("mode0: max abs error %0d, mean abs error %0.3f", max_under0,
               real'(sum_abs0) / real'(NPAIRS));
      $display("mode1: max abs error %0d, mean abs error %0.3f",
               (max_over1 > max_under1) ? max_over1 : max_under1,
               real'(sum_abs1) / real'(NPAIRS));
      $display("note: mode1 gives %0d for a zero operand, a known approximation error", BONUS);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule